// File: doc/BRIEF.md
# Threshold-Flagged Synchronous FIFO

This block is a small synchronous first-in first-out buffer. It is meant to sit between a serial bus engine and the logic that feeds or drains it. Examples are an outbound queue of command words, which are 11 bits wide, and an inbound queue of received bytes, which are 8 bits wide. Words leave in the order they arrived. The oldest word is always visible on the read data output (first-word-fall-through), so a read strobe simply consumes it.

Alongside the data path the block reports an occupancy count and four status flags. It also produces single-cycle event pulses for a push into a full buffer and for a pop from an empty buffer. A level flag compares the occupancy against a threshold value. In the outbound direction the flag asks for more data. In the inbound direction it asks for draining. The direction is fixed by a parameter. A flush input holds the buffer empty for as long as it is high.

Top module: `thresh_fifo`

## Requirements
- R1: Words are returned in the order written. Whenever the buffer holds at least one word, `rd_data` shows the oldest word, without any read strobe being needed.
- R2: `level` counts the stored words, from 0 to DEPTH (16 by default). It rises by one on an accepted push, falls by one on an accepted pop, and changes at the clock edge that samples the request.
- R3: A push while `level` equals DEPTH is discarded, even if a pop happens in the same cycle. `ovf_pulse` is high for exactly the one cycle after that edge. A pop in the same cycle is still performed.
- R4: A pop while the buffer is empty changes nothing and raises `unf_pulse` for the one cycle after that edge. A push in the same cycle is accepted.
- R5: A push together with a pop, when the buffer is neither full nor empty, leaves `level` unchanged.
- R6: `full` is high when `level` equals DEPTH and `empty` is high when `level` is 0. `not_full` and `not_empty` are their complements.
- R7: While `flush` is sampled high, the buffer becomes and stays empty, pushes and pops are ignored, and neither event pulse is raised.
- R8: A `thr` value above DEPTH-1 acts as a threshold of DEPTH. Values from 0 to DEPTH-1 act as written.
- R9: With TX_DIR=1, `thr_flag` is high when `level` is at or below the effective threshold.
- R10: With TX_DIR=0, `thr_flag` is high when `level` is at or above the effective threshold plus one.
- R11: After reset the buffer is empty, `level` is 0, `empty` and `not_full` are high, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear, holds the buffer empty |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Oldest stored word (first-word-fall-through) |
| thr | input | THR_W | Threshold setting, clamped to DEPTH |
| level | output | CW | Stored word count |
| full | output | 1 | Level equals DEPTH |
| not_full | output | 1 | Level below DEPTH |
| empty | output | 1 | Level is zero |
| not_empty | output | 1 | Level above zero |
| thr_flag | output | 1 | Threshold comparison result |
| ovf_pulse | output | 1 | Push into a full buffer was dropped |
| unf_pulse | output | 1 | Pop from an empty buffer was attempted |

## Verification
The count, the status flags, the head word and both event pulses all come from registers. They are due in the first cycle after the edge that samples a request. The bench therefore drives inputs on the falling edge, lets one rising edge pass, and samples shortly after it. `thr_flag` depends combinationally on the threshold input and the registered count. It is checked in the same window, with the threshold held steady across the edge. Two instances run side by side, one per direction and width, and each is compared against a queue model kept in the bench.

// File: rtl/thresh_fifo.sv
module thresh_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 8,
  parameter bit TX_DIR = 1'b0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [THR_W-1:0]  thr,
  output logic [CW-1:0]     level,
  output logic              full,
  output logic              not_full,
  output logic              empty,
  output logic              not_empty,
  output logic              thr_flag,
  output logic              ovf_pulse,
  output logic              unf_pulse
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic              push, pop;
  logic [CW:0]       thr_eff;
  logic [CW:0]       cnt_x;

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign not_full  = ~full;
  assign not_empty = ~empty;
  assign level     = cnt;
  assign rd_data   = mem[rptr];

  assign push = wr_en & ~full & ~flush;
  assign pop  = rd_en & ~empty & ~flush;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      ovf_pulse <= 1'b0;
      unf_pulse <= 1'b0;
    end else if (flush) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      ovf_pulse <= 1'b0;
      unf_pulse <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      ovf_pulse <= wr_en & full;
      unf_pulse <= rd_en & empty;
    end
  end

  assign thr_eff = (thr > THR_W'(DEPTH - 1)) ? (CW+1)'(DEPTH) : (CW+1)'(thr);
  assign cnt_x   = {1'b0, cnt};

  generate
    if (TX_DIR) begin : g_tx
      assign thr_flag = (cnt_x <= thr_eff);
    end else begin : g_rx
      assign thr_flag = (cnt_x >= thr_eff + 1'b1);
    end
  endgenerate

endmodule

// File: rtl/thresh_fifo_chk.sv
module thresh_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          wr_en,
  input logic          rd_en,
  input logic [CW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          ovf_pulse,
  input logic          unf_pulse
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) level <= CW'(DEPTH)); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> (ovf_pulse && level == CW'(DEPTH))); // R3
  AST_UNDERFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !flush) |=> unf_pulse); // R4
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !full && !empty && !flush) |=> $stable(level)); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !ovf_pulse && !unf_pulse)); // R7

endmodule

bind thresh_fifo thresh_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
  .level(level), .full(full), .empty(empty),
  .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
);

// File: tb/thresh_fifo_bench.sv
`timescale 1ns/1ps
module thresh_fifo_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wd = '0, thr = '0;

  logic [7:0]  r_data;  logic [10:0] t_data;
  logic [4:0]  r_lvl, t_lvl;
  logic r_full, r_nfull, r_empty, r_nempty, r_flag, r_ovf, r_unf;
  logic t_full, t_nfull, t_empty, t_nempty, t_flag, t_ovf, t_unf;

  thresh_fifo #(.DATA_W(8), .TX_DIR(1'b0)) u_thresh_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wd),
    .rd_en(rd_en), .rd_data(r_data), .thr(thr), .level(r_lvl), .full(r_full),
    .not_full(r_nfull), .empty(r_empty), .not_empty(r_nempty),
    .thr_flag(r_flag), .ovf_pulse(r_ovf), .unf_pulse(r_unf));

  thresh_fifo #(.DATA_W(11), .TX_DIR(1'b1)) u_thresh_fifo_tx (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data({3'b101, wd}),
    .rd_en(rd_en), .rd_data(t_data), .thr(thr), .level(t_lvl), .full(t_full),
    .not_full(t_nfull), .empty(t_empty), .not_empty(t_nempty),
    .thr_flag(t_flag), .ovf_pulse(t_ovf), .unf_pulse(t_unf));

  typedef struct packed {
    logic fl, wr, rd; logic [7:0] d, t;
    logic [4:0] lvl; logic ovf, unf, rxf, txf;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,8'hA1,8'd0,  5'd1,1'b0,1'b0,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,8'hB2,8'd2,  5'd2,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,8'hC3,8'd2,  5'd2,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,8'h00,8'd1,  5'd1,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,8'h00,8'd1,  5'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,8'h00,8'd1,  5'd0,1'b0,1'b1,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,8'hD4,8'd0,  5'd1,1'b0,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,8'hE5,8'd0,  5'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,8'h00,8'd200,5'd0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,8'hF6,8'd200,5'd1,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,8'h00,8'd0,  5'd0,1'b0,1'b0,1'b0,1'b1}
  };

  int checks = 0, fails = 0;
  logic [7:0] q[$];
  bit m_ovf = 1'b0, m_unf = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input bit fl, input bit wr, input bit rd, input logic [7:0] d);
    int s = q.size();
    if (fl) begin
      q.delete(); m_ovf = 1'b0; m_unf = 1'b0;
    end else begin
      m_unf = rd && (s == 0);
      m_ovf = wr && (s == 16);
      if (rd && s > 0) void'(q.pop_front());
      if (wr && s < 16) q.push_back(d);
    end
  endtask

  task automatic step(input bit fl, input bit wr, input bit rd, input logic [7:0] d, input logic [7:0] t);
    @(negedge clk);
    flush = fl; wr_en = wr; rd_en = rd; wd = d; thr = t;
    @(posedge clk);
    model(fl, wr, rd, d);
    #1;
    flush = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic check_model(input string tag);
    int eff = (thr > 15) ? 16 : int'(thr);
    int s = q.size();
    chk({tag, " R2 level rx"}, r_lvl, s);
    chk({tag, " R2 level tx"}, t_lvl, s);
    chk({tag, " R6 full"}, r_full, s == 16);
    chk({tag, " R6 empty"}, r_empty, s == 0);
    chk({tag, " R6 not_full"}, r_nfull, s != 16);
    chk({tag, " R6 not_empty"}, t_nempty, s != 0);
    chk({tag, " R3 ovf"}, r_ovf, m_ovf);
    chk({tag, " R4 unf"}, t_unf, m_unf);
    chk({tag, " R10 rx flag"}, r_flag, s >= eff + 1);
    chk({tag, " R9 tx flag"}, t_flag, s <= eff);
    if (s > 0) begin
      chk({tag, " R1 head rx"}, r_data, q[0]);
      chk({tag, " R1 head tx"}, t_data, {3'b101, q[0]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 level", r_lvl, 0);
    chk("R11 empty", r_empty, 1);
    chk("R11 not_full", r_nfull, 1);
    chk("R11 full", t_full, 0);
    chk("R11 not_empty", r_nempty, 0);
    chk("R11 ovf", r_ovf, 0);
    chk("R11 unf", t_unf, 0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].fl, VECS[i].wr, VECS[i].rd, VECS[i].d, VECS[i].t);
      chk("R2 R5 R7 table level", r_lvl, VECS[i].lvl);
      chk("R3 table ovf", r_ovf, VECS[i].ovf);
      chk("R4 table unf", r_unf, VECS[i].unf);
      chk("R10 R8 table rx flag", r_flag, VECS[i].rxf);
      chk("R9 R8 table tx flag", t_flag, VECS[i].txf);
      check_model("table");
    end

    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b1, 1'b0, 8'(8'h40 + i), 8'd15);
      check_model("R1 fill");
    end
    chk("R6 full at depth", t_full, 1);
    chk("R10 rx at depth thr15", r_flag, 1);
    chk("R9 tx at depth thr15", t_flag, 0);

    step(1'b0, 1'b0, 1'b0, 8'h00, 8'd99);
    chk("R8 clamp rx", r_flag, 0);
    chk("R8 clamp tx", t_flag, 1);

    step(1'b0, 1'b1, 1'b0, 8'h77, 8'd99);
    chk("R3 ovf pulse", r_ovf, 1);
    chk("R3 level kept", r_lvl, 16);
    check_model("R3 push full");
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'd99);
    chk("R3 ovf one cycle", t_ovf, 0);

    step(1'b0, 1'b1, 1'b1, 8'h78, 8'd99);
    chk("R3 push+pop full ovf", t_ovf, 1);
    chk("R3 push+pop full level", t_lvl, 15);
    check_model("R3 push+pop full");

    for (int i = 0; i < 15; i++) begin
      step(1'b0, 1'b0, 1'b1, 8'h00, 8'd7);
      check_model("R1 drain");
    end

    step(1'b0, 1'b1, 1'b0, 8'h91, 8'd3);
    step(1'b0, 1'b1, 1'b0, 8'h92, 8'd3);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b1, 8'h93, 8'd3);
      chk("R7 flush held level", r_lvl, 0);
      chk("R7 flush no unf", r_unf, 0);
      check_model("R7 flush");
    end
    step(1'b0, 1'b1, 1'b0, 8'hA0, 8'd3);
    check_model("R7 after flush");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule